// File: doc/BRIEF.md
# Streaming Dot-Product Accumulator

This block forms the inner product of two unsigned integer vectors that arrive one element pair per clock. Each pair passes through a four-stage multiplier pipeline. The product then goes into a four-stage adder ring whose output feeds its own input. Because the ring is four stages deep, consecutive products fall into four separate running sums. Each lane collects every fourth product. When the stream ends, the block lets the multiplier empty, folds the four lanes into one scalar in two register steps, and raises a one-cycle done strobe with the result.

The producer marks each pair with a valid flag and marks the final pair with a last flag. Valid may drop in the middle of a vector. Those idle cycles put a zero product into the ring and leave the total unchanged. Once the last pair is taken, the input is ignored until the result appears. The first pair of the next vector may be offered in the same cycle that done is high. Taking that first pair clears every segment register, so nothing carries over from the previous vector.

Top module: `dot_stream_acc`

## Requirements
- R1: After reset, out_done is 0 and out_sum is 0.
- R2: The result equals the sum over all accepted pairs of in_a*in_b. Both operands are unsigned. The sum is taken modulo 2^ACC_W, where ACC_W = 2*ELEM_W + clog2(MAX_LEN).
- R3: out_done is high for exactly one cycle. It rises on the 6th rising edge after the edge that accepted the pair carrying in_last, and at no other time.
- R4: A cycle with in_valid low inside a vector adds nothing to the result, whatever values are on in_a and in_b.
- R5: Vectors of any length from 1 upward give the correct sum, including lengths that are not a multiple of 4. Lanes that receive no element contribute zero.
- R6: in_valid, in_last, in_a and in_b are ignored from the edge after the last pair is accepted through the edge that raises out_done.
- R7: A new vector may start in the cycle where out_done is high. Its result does not depend on any earlier vector.
- R8: out_sum changes only on the edge that raises out_done. It holds its value at all other times.
- R9: A vector of MAX_LEN-scale length with every operand at full scale gives the exact sum without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | An element pair is present |
| in_last | input | 1 | The present pair ends the vector |
| in_a | input | ELEM_W | Element of the first vector |
| in_b | input | ELEM_W | Element of the second vector |
| out_sum | output | ACC_W | Inner-product result |
| out_done | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench builds the block with ELEM_W = 8 and MAX_LEN = 1024, which gives a 26-bit accumulator. A 1000-element vector of 255*255 products then comes within about 3 % of the accumulator's limit, so any carry lost in the lanes or in the reduction shows up. Lengths 1, 3, 4, 5, 7, 8 and 9 place the last element in each lane position. Random gaps in valid shift which lane each element lands in. Junk driven during draining, and back-to-back vectors, cover the ignore window and the clearing on start.

// File: rtl/dsa_pkg.sv
package dsa_pkg;
  // Depth of both the multiplier and the adder pipelines; the ring
  // therefore carries this many interleaved partial sums.
  localparam int SEGS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_RED1,
    ST_RED2
  } st_e;
endpackage

// File: rtl/dsa_mul_pipe.sv
module dsa_mul_pipe
  import dsa_pkg::*;
#(
  parameter int ELEM_W = 8,
  localparam int PW = 2 * ELEM_W,
  localparam int PD = SEGS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ld_i,
  input  logic [ELEM_W-1:0] a_i,
  input  logic [ELEM_W-1:0] b_i,
  output logic [PW-1:0]     prod_o,
  output logic              vld_o
);
  // Segment 1 holds operands, segments 2..SEGS hold the product.
  logic [ELEM_W-1:0] a_q, a_n, b_q, b_n;
  logic              v0_q, v0_n;
  logic [PW-1:0]     p_q [PD];
  logic [PW-1:0]     p_n [PD];
  logic [PD-1:0]     v_q, v_n;

  always_comb begin
    a_n  = ld_i ? a_i : '0;
    b_n  = ld_i ? b_i : '0;
    v0_n = ld_i;
  end

  assign p_n[0] = clr_i ? '0 : PW'(a_q) * PW'(b_q);
  assign v_n[0] = clr_i ? 1'b0 : v0_q;

  for (genvar g = 1; g < PD; g++) begin : g_dly
    assign p_n[g] = clr_i ? '0 : p_q[g-1];
    assign v_n[g] = clr_i ? 1'b0 : v_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      v0_q <= 1'b0;
      v_q  <= '0;
      for (int i = 0; i < PD; i++) p_q[i] <= '0;
    end else begin
      a_q  <= a_n;
      b_q  <= b_n;
      v0_q <= v0_n;
      v_q  <= v_n;
      for (int i = 0; i < PD; i++) p_q[i] <= p_n[i];
    end
  end

  assign prod_o = p_q[PD-1];
  assign vld_o  = v_q[PD-1];

  // R2
  mul_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> prod_o == PW'($past(a_i, 4)) * PW'($past(b_i, 4)));
endmodule

// File: rtl/dsa_add_ring.sv
module dsa_add_ring
  import dsa_pkg::*;
#(
  parameter int ACC_W = 26,
  parameter int PW    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       en_i,
  input  logic [PW-1:0]              prod_i,
  output logic [SEGS-1:0][ACC_W-1:0] lanes_o
);
  logic [SEGS-1:0][ACC_W-1:0] s_q, s_n;

  // The segment leaving the ring is added to the incoming product and
  // re-enters at the head: SEGS interleaved partial sums.
  always_comb begin
    s_n = s_q;
    if (clr_i) begin
      s_n = '0;
    end else if (en_i) begin
      s_n[0] = s_q[SEGS-1] + ACC_W'(prod_i);
      for (int g = 1; g < SEGS; g++) s_n[g] = s_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '0;
    else        s_q <= s_n;
  end

  assign lanes_o = s_q;

  // R4
  zero_lap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clr_i && prod_i == '0) |=> s_q[0] == $past(s_q[SEGS-1]));

  // R6
  frozen_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(s_q));
endmodule

// File: rtl/dsa_reduce.sv
module dsa_reduce
  import dsa_pkg::*;
#(
  parameter int ACC_W = 26
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go1_i,
  input  logic                       go2_i,
  input  logic [SEGS-1:0][ACC_W-1:0] lanes_i,
  output logic [ACC_W-1:0]           sum_o,
  output logic                       done_o
);
  // Two-level tree for the four lanes: pair sums, then the total.
  logic [ACC_W-1:0] lo_q, lo_n, hi_q, hi_n, sum_q, sum_n;
  logic             done_q;

  always_comb begin
    lo_n  = go1_i ? lanes_i[0] + lanes_i[1] : lo_q;
    hi_n  = go1_i ? lanes_i[2] + lanes_i[3] : hi_q;
    sum_n = go2_i ? lo_q + hi_q : sum_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      sum_q  <= '0;
      done_q <= 1'b0;
    end else begin
      lo_q   <= lo_n;
      hi_q   <= hi_n;
      sum_q  <= sum_n;
      done_q <= go2_i;
    end
  end

  assign sum_o  = sum_q;
  assign done_o = done_q;

  // R8
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(sum_o));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/dot_stream_acc.sv
module dot_stream_acc
  import dsa_pkg::*;
#(
  parameter int  ELEM_W  = 8,
  parameter int  MAX_LEN = 1024,
  localparam int PW      = 2 * ELEM_W,
  localparam int ACC_W   = PW + $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [ELEM_W-1:0] in_a,
  input  logic [ELEM_W-1:0] in_b,
  output logic [ACC_W-1:0]  out_sum,
  output logic              out_done
);
  localparam int CW = $clog2(SEGS);

  st_e                        st_q, st_n;
  logic [CW-1:0]              cnt_q, cnt_n;
  logic                       accept, start, ring_en;
  logic [PW-1:0]              mul_prod;
  logic                       mul_vld;
  logic [SEGS-1:0][ACC_W-1:0] lanes;

  assign accept  = in_valid && (st_q == ST_IDLE || st_q == ST_RUN);
  assign start   = accept && st_q == ST_IDLE;
  assign ring_en = st_q == ST_RUN || st_q == ST_DRAIN;

  always_comb begin
    st_n  = st_q;
    cnt_n = (st_q == ST_DRAIN) ? cnt_q + 1'b1 : '0;
    case (st_q)
      ST_IDLE:  if (accept) st_n = in_last ? ST_DRAIN : ST_RUN;
      ST_RUN:   if (accept && in_last) st_n = ST_DRAIN;
      ST_DRAIN: if (cnt_q == CW'(SEGS - 1)) st_n = ST_RED1;
      ST_RED1:  st_n = ST_RED2;
      ST_RED2:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

  dsa_mul_pipe #(.ELEM_W(ELEM_W)) u_mul (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (start),
    .ld_i   (accept),
    .a_i    (in_a),
    .b_i    (in_b),
    .prod_o (mul_prod),
    .vld_o  (mul_vld)
  );

  dsa_add_ring #(.ACC_W(ACC_W), .PW(PW)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start),
    .en_i    (ring_en),
    .prod_i  (mul_prod),
    .lanes_o (lanes)
  );

  dsa_reduce #(.ACC_W(ACC_W)) u_red (
    .clk     (clk),
    .rst_n   (rst_n),
    .go1_i   (st_q == ST_RED1),
    .go2_i   (st_q == ST_RED2),
    .lanes_i (lanes),
    .sum_o   (out_sum),
    .done_o  (out_done)
  );

  // R6
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RED1) |-> !mul_vld);

  // R3
  red_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RED2) |=> out_done);

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> lanes == '0);
endmodule

// File: tb/dot_stream_acc_tb.sv
`timescale 1ns/1ps
module dot_stream_acc_tb;
  localparam int ELEM_W  = 8;
  localparam int MAX_LEN = 1024;
  localparam int ACC_W   = 2 * ELEM_W + $clog2(MAX_LEN);
  localparam longint MASK = (64'd1 << ACC_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_last;
  logic [ELEM_W-1:0] in_a, in_b;
  logic [ACC_W-1:0]  out_sum;
  logic              out_done;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dot_stream_acc #(.ELEM_W(ELEM_W), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_a(in_a), .in_b(in_b), .out_sum(out_sum), .out_done(out_done)
  );

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: accepts pairs while not busy, records results
  // in a queue with the edge on which they must appear.
  int     cyc = 0;
  bit     busy = 0, invec = 0;
  longint acc = 0, hold = 0;
  longint pend_q[$];
  int     due_q[$];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      busy = 0; invec = 0; acc = 0;
    end else if (!busy && in_valid) begin
      if (!invec) acc = 0;
      invec = 1;
      acc += longint'(in_a) * longint'(in_b);
      if (in_last) begin
        pend_q.push_back(acc & MASK);
        due_q.push_back(cyc + 6);
        busy = 1; invec = 0;
      end
    end else if (busy && due_q.size() > 0 && cyc == due_q[0]) begin
      busy = 0;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (due_q.size() > 0 && cyc == due_q[0]) begin
        chk(out_done == 1'b1, "R3 done", longint'(out_done), 1);
        chk(longint'(out_sum) == pend_q[0], "R2 sum", longint'(out_sum), pend_q[0]);
        hold = pend_q[0];
        void'(pend_q.pop_front());
        void'(due_q.pop_front());
      end else begin
        chk(out_done == 1'b0, "R3 no-done", longint'(out_done), 0);
        chk(longint'(out_sum) == hold, "R8 hold", longint'(out_sum), hold);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(bit v, bit l, logic [ELEM_W-1:0] x, logic [ELEM_W-1:0] y);
    @(negedge clk);
    in_valid = v; in_last = l; in_a = x; in_b = y;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, '0, '0);
  endtask

  // mode 0: random, 1: full scale, 2: ramp
  task automatic run_vec(int k, int mode, bit gaps, bit junk, string tag);
    longint e = 0;
    logic [ELEM_W-1:0] x, y;
    for (int i = 0; i < k; i++) begin
      if (gaps && ($urandom % 3 == 0))
        drive(1'b0, 1'b1, ELEM_W'($urandom), ELEM_W'($urandom));
      case (mode)
        1:       begin x = '1; y = '1; end
        2:       begin x = ELEM_W'(i + 1); y = ELEM_W'(2 * i + 3); end
        default: begin x = ELEM_W'($urandom); y = ELEM_W'($urandom); end
      endcase
      e += longint'(x) * longint'(y);
      drive(1'b1, i == k - 1, x, y);
    end
    for (int j = 0; j < 6; j++)
      drive(junk, junk && j == 2, ELEM_W'($urandom), ELEM_W'($urandom));
    @(posedge clk); #1;
    chk(out_done == 1'b1, {tag, " strobe"}, longint'(out_done), 1);
    chk(longint'(out_sum) == (e & MASK), tag, longint'(out_sum), e & MASK);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #0.5;
    // R1
    chk(out_done == 1'b0, "R1 done", longint'(out_done), 0);
    chk(out_sum == '0, "R1 sum", longint'(out_sum), 0);
    idle(2);
    run_vec(1, 0, 0, 0, "R5 k1");
    idle(3);
    run_vec(4, 2, 0, 0, "R2 k4");
    run_vec(5, 2, 0, 0, "R5 k5");
    run_vec(3, 0, 0, 0, "R5 k3");
    run_vec(7, 0, 0, 0, "R5 k7");
    run_vec(8, 0, 0, 0, "R2 k8");
    run_vec(20, 0, 1, 0, "R4 gaps");
    run_vec(9, 0, 0, 1, "R6 junk");
    run_vec(3, 2, 0, 0, "R7 back2back");
    idle(10);
    // R8: result still held after idle time
    chk(longint'(out_sum) == hold, "R8 idle", longint'(out_sum), hold);
    run_vec(1000, 1, 0, 0, "R9 fullscale");
    run_vec(100, 0, 1, 1, "R2 rand");
    idle(4);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule